// File: doc/BRIEF.md
# Return-from-interrupt bus cycle sequencer

This block produces the special I/O bus transaction that tells daisy-chained interrupt peripherals that an interrupt service routine has finished. The transaction replays the two opcode bytes of a return-from-interrupt instruction as two pseudo instruction fetches. Each byte is placed on both halves of a 16-bit data bus.

A one-cycle start request, taken while the block is idle, launches a fixed sequence of ten I/O clock cycles. Cycles 1 to 5 carry the first opcode byte and cycles 6 to 10 carry the second. The fetch indicator and the read strobe are active low. They mark the first fetch in cycles 2 to 4 and the second fetch in cycles 6 to 9.

An active-low wait input is captured in the middle of cycles 3, 5 and 9. Capturing it low repeats the current cycle. At cycles 3 and 9 this lengthens the read-strobe low time. At cycle 5 it widens the gap between the two fetches, which gives the peripherals' daisy chain time to settle. A busy flag covers the whole transaction, and a done pulse follows it.

Top module: `reti_seq`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising clock edge) returns the block to idle, even in the middle of a transaction. In idle, `busy`, `done` and `data_oe` are 0, `fetch_n` and `rd_n` are 1, and `data_out` is 0.
- R2: When `start` is 1 at a rising edge while the block is idle, cycle 1 begins at that edge. With no wait states, cycles 1 to 10 follow one per clock, and `busy` is 1 during all of them.
- R3: `start` has no effect while `busy` is 1. The running sequence continues unchanged.
- R4: In every transaction cycle, including repeated ones, `data_oe` is 1. `data_out` is 16'hEDED in cycles 1 to 5 and 16'h4D4D in cycles 6 to 10.
- R5: `fetch_n` and `rd_n` are 0 in cycles 2, 3 and 4 and in cycles 6, 7, 8 and 9. They are 1 in cycles 1, 5 and 10 and in idle.
- R6: `wait_n` is captured at the falling edge in the middle of a cycle. If it is captured low in cycle 3, cycle 3 is repeated for one more clock. This repeats for as long as it stays low.
- R7: If `wait_n` is captured low in cycle 5, cycle 5 is repeated, which lengthens the strobe-high gap between the two fetches.
- R8: If `wait_n` is captured low in cycle 9, cycle 9 is repeated, which lengthens the second read-strobe low time.
- R9: `wait_n` has no effect in idle or in cycles 1, 2, 4, 6, 7, 8 and 10.
- R10: `done` is 1 for exactly the one clock that follows cycle 10, and `busy` is 0 in that clock. A `start` in that clock is accepted, so the next transaction can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch request, taken while idle |
| wait_n | input | 1 | Wait request, active low, captured mid-cycle |
| data_out | output | 16 | Opcode byte replicated on both halves of the bus |
| data_oe | output | 1 | Data bus enable, high for the whole transaction |
| fetch_n | output | 1 | Fetch indicator, active low |
| rd_n | output | 1 | Read strobe, active low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse after the last cycle |

## Verification
The bench builds the block with its default parameters. These are ten cycles, opcode bytes 8'hED and 8'h4D, sample points 3, 5 and 9, and fetch windows 2–4 and 6–9. With these values every sample point, both fetch windows and the halfway switch of the data bus can be reached in short runs.

The bench stalls at each sample point by zero, one and several cycles. It holds the wait input low on every other cycle and in idle to show that it is ignored there. It also pulses start during a transaction and runs transactions back to back. Finally, it resets in the middle of a stretched fetch.

// File: rtl/reti_pkg.sv
package reti_pkg;

  // True when phase p lies inside the inclusive window [lo, hi]
  function automatic logic in_window(input int p, input int lo, input int hi);
    return (p >= lo) && (p <= hi);
  endfunction

  // True when phase p is one of the three mid-cycle wait capture points
  function automatic logic is_wait_point(input int p, input int a, input int b, input int c);
    return (p == a) || (p == b) || (p == c);
  endfunction

  // Opcode byte replicated across a bus of width w (w a multiple of 8)
  function automatic logic [63:0] replicate_byte(input logic [7:0] b, input int w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < w / 8) r[i*8 +: 8] = b;
    end
    return r;
  endfunction

endpackage

// File: rtl/reti_wait_sampler.sv
module reti_wait_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n,
  output logic wait_smp_n
);
  // Falling-edge capture places the sample in the middle of each cycle
  always_ff @(negedge clk) begin
    if (!rst_n) wait_smp_n <= 1'b1;
    else        wait_smp_n <= wait_n;
  end
endmodule

// File: rtl/reti_phase_ctl.sv
module reti_phase_ctl #(
  parameter int N_CYC  = 10,
  parameter int SMP_A  = 3,
  parameter int SMP_B  = 5,
  parameter int SMP_C  = 9,
  localparam int PW    = $clog2(N_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wait_smp_n,
  output logic [PW-1:0] phase,
  output logic          stall,
  output logic          busy,
  output logic          done
);
  import reti_pkg::*;

  logic [PW-1:0] phase_q;
  logic          done_q;
  logic          launch;
  logic          at_point;
  logic          last;

  assign busy     = (phase_q != '0);
  assign launch   = !busy && start;
  assign at_point = is_wait_point(int'(phase_q), SMP_A, SMP_B, SMP_C);
  assign stall    = busy && at_point && !wait_smp_n;
  assign last     = (phase_q == PW'(N_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= busy && last && !stall;
      if (launch)            phase_q <= PW'(1);
      else if (busy) begin
        if (stall)           phase_q <= phase_q;
        else if (last)       phase_q <= '0;
        else                 phase_q <= phase_q + PW'(1);
      end
    end
  end

  assign phase = phase_q;
  assign done  = done_q;
endmodule

// File: rtl/reti_bus_shaper.sv
module reti_bus_shaper #(
  parameter int          DATA_W = 16,
  parameter int          N_CYC  = 10,
  parameter logic [7:0]  OPC1   = 8'hED,
  parameter logic [7:0]  OPC2   = 8'h4D,
  parameter int          F1_LO  = 2,
  parameter int          F1_HI  = 4,
  parameter int          F2_LO  = 6,
  parameter int          F2_HI  = 9,
  localparam int         PW     = $clog2(N_CYC + 1),
  localparam int         HALF   = N_CYC / 2
) (
  input  logic [PW-1:0]     phase,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              fetch_n,
  output logic              rd_n
);
  import reti_pkg::*;

  logic        active;
  logic        first_half;
  logic        strobe;
  logic [63:0] word1;
  logic [63:0] word2;

  assign word1      = replicate_byte(OPC1, DATA_W);
  assign word2      = replicate_byte(OPC2, DATA_W);
  assign active     = in_window(int'(phase), 1, N_CYC);
  assign first_half = in_window(int'(phase), 1, HALF);
  assign strobe     = in_window(int'(phase), F1_LO, F1_HI) ||
                      in_window(int'(phase), F2_LO, F2_HI);

  always_comb begin
    if (!active)         data_out = '0;
    else if (first_half) data_out = word1[DATA_W-1:0];
    else                 data_out = word2[DATA_W-1:0];
  end

  assign data_oe = active;
  assign fetch_n = !strobe;
  assign rd_n    = !strobe;
endmodule

// File: rtl/reti_seq.sv
module reti_seq #(
  parameter int         DATA_W = 16,
  parameter int         N_CYC  = 10,
  parameter logic [7:0] OPC1   = 8'hED,
  parameter logic [7:0] OPC2   = 8'h4D,
  parameter int         SMP_A  = 3,
  parameter int         SMP_B  = 5,
  parameter int         SMP_C  = 9,
  parameter int         F1_LO  = 2,
  parameter int         F1_HI  = 4,
  parameter int         F2_LO  = 6,
  parameter int         F2_HI  = 9,
  localparam int        PW     = $clog2(N_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wait_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              fetch_n,
  output logic              rd_n,
  output logic              busy,
  output logic              done
);
  // Named internal events, observed by the bound checker
  logic          wait_smp_n;
  logic [PW-1:0] phase;
  logic          stall;

  reti_wait_sampler u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_n     (wait_n),
    .wait_smp_n (wait_smp_n)
  );

  reti_phase_ctl #(
    .N_CYC (N_CYC), .SMP_A (SMP_A), .SMP_B (SMP_B), .SMP_C (SMP_C)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .wait_smp_n (wait_smp_n),
    .phase      (phase),
    .stall      (stall),
    .busy       (busy),
    .done       (done)
  );

  reti_bus_shaper #(
    .DATA_W (DATA_W), .N_CYC (N_CYC), .OPC1 (OPC1), .OPC2 (OPC2),
    .F1_LO (F1_LO), .F1_HI (F1_HI), .F2_LO (F2_LO), .F2_HI (F2_HI)
  ) u_shape (
    .phase    (phase),
    .data_out (data_out),
    .data_oe  (data_oe),
    .fetch_n  (fetch_n),
    .rd_n     (rd_n)
  );
endmodule

// File: rtl/reti_seq_chk.sv
module reti_seq_chk #(
  parameter int         DATA_W = 16,
  parameter int         N_CYC  = 10,
  parameter logic [7:0] OPC1   = 8'hED,
  parameter logic [7:0] OPC2   = 8'h4D,
  parameter int         SMP_A  = 3,
  parameter int         SMP_B  = 5,
  parameter int         SMP_C  = 9,
  localparam int        PW     = $clog2(N_CYC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wait_smp_n,
  input logic [PW-1:0]     phase,
  input logic              stall,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              fetch_n,
  input logic              rd_n,
  input logic              busy,
  input logic              done
);
  localparam logic [DATA_W-1:0] W1 = {(DATA_W/8){OPC1}};
  localparam logic [DATA_W-1:0] W2 = {(DATA_W/8){OPC2}};

  a_r4_oe_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe == busy);

  a_r4_bus_value: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (data_out == W1 || data_out == W2));

  a_r5_strobes_agree: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_n == rd_n);

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (phase == PW'(1)));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stall && phase != PW'(N_CYC)) |=> (phase == $past(phase) + PW'(1)));

  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != PW'(N_CYC)) |=> busy);

  a_r6_hold_third: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PW'(SMP_A) && !wait_smp_n) |=> (phase == PW'(SMP_A)));

  a_r7_hold_fifth: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PW'(SMP_B) && !wait_smp_n) |=> (phase == PW'(SMP_B)));

  a_r8_hold_ninth: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PW'(SMP_C) && !wait_smp_n) |=> (phase == PW'(SMP_C)));

  a_r10_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PW'(N_CYC)) |=> (done && !busy));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind reti_seq reti_seq_chk #(
  .DATA_W (DATA_W), .N_CYC (N_CYC), .OPC1 (OPC1), .OPC2 (OPC2),
  .SMP_A (SMP_A), .SMP_B (SMP_B), .SMP_C (SMP_C)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .wait_smp_n (wait_smp_n),
  .phase      (phase),
  .stall      (stall),
  .data_out   (data_out),
  .data_oe    (data_oe),
  .fetch_n    (fetch_n),
  .rd_n       (rd_n),
  .busy       (busy),
  .done       (done)
);

// File: tb/reti_seq_test.sv
module reti_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wait_n = 1'b1;
  logic [15:0] data_out;
  logic        data_oe, fetch_n, rd_n, busy, done;

  always #5 clk = ~clk;

  reti_seq uut (
    .clk (clk), .rst_n (rst_n), .start (start), .wait_n (wait_n),
    .data_out (data_out), .data_oe (data_oe), .fetch_n (fetch_n),
    .rd_n (rd_n), .busy (busy), .done (done)
  );

  typedef struct {
    int    k;
    bit    d;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   pend_done = 0;
  bit   finished = 0;

  // Expected bus view of a phase, taken from the requirement text
  function automatic logic [15:0] exp_data(input int k);
    if (k == 0) return 16'h0000;
    if (k <= 5) return 16'hEDED;
    return 16'h4D4D;
  endfunction

  function automatic logic exp_strobe_n(input int k);
    case (k)
      2, 3, 4, 6, 7, 8, 9: return 1'b0;
      default:             return 1'b1;
    endcase
  endfunction

  // Driver: push the expectation of this cycle, then set the inputs for its end
  task automatic step(input int k, input bit d, input bit st, input bit w,
                      input bit r, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.k = k; e.d = d; e.tag = tag;
    q.push_back(e);
    start  = st;
    wait_n = w;
    rst_n  = r;
  endtask

  task automatic idle(input int n, input bit w);
    for (int i = 0; i < n; i++) begin
      step(0, pend_done, 0, w, 1, pend_done ? "R10 done pulse" : (w ? "R1 idle" : "R9 idle wait"));
      pend_done = 0;
    end
  endtask

  // One transaction with wait counts at the three capture points
  task automatic txn(input int w3, input int w5, input int w9,
                     input bit poke, input int abort_at);
    step(0, pend_done, 1, 1, 1, pend_done ? "R10 back-to-back launch" : "R2 launch");
    pend_done = 0;
    for (int k = 1; k <= 10; k++) begin
      int nw;
      bit samp;
      samp = (k == 3) || (k == 5) || (k == 9);
      nw   = (k == 3) ? w3 : (k == 5) ? w5 : (k == 9) ? w9 : 0;
      for (int j = 0; j <= nw; j++) begin
        string t;
        bit    w;
        w = samp ? (j == nw) : 1'b0;
        t = $sformatf("R2 R4 R5 phase %0d", k);
        if (samp && j > 0)
          t = {t, (k == 3) ? " R6 hold" : (k == 5) ? " R7 hold" : " R8 hold"};
        if (!samp) t = {t, " R9"};
        if (poke)  t = {t, " R3"};
        if (abort_at == k && j == nw) begin
          step(k, 0, poke, w, 0, {t, " before reset"});
          step(0, 0, 0, 1, 1, "R1 reset mid-transaction");
          return;
        end
        step(k, 0, poke, w, 1, t);
      end
    end
    pend_done = 1;
  endtask

  // Monitor: compare outputs late in each cycle
  initial begin
    forever begin
      @(posedge clk);
      #7;
      if (q.size() > 0) begin
        exp_t e;
        logic [15:0] ed;
        logic eo, es, eb;
        e  = q.pop_front();
        ed = exp_data(e.k);
        eo = (e.k != 0);
        es = exp_strobe_n(e.k);
        eb = (e.k != 0);
        n_chk++;
        if (data_out !== ed || data_oe !== eo || fetch_n !== es ||
            rd_n !== es || busy !== eb || done !== e.d) begin
          n_fail++;
          $display("FAIL %s: got data=%h oe=%b fetch_n=%b rd_n=%b busy=%b done=%b, expected data=%h oe=%b fetch_n=%b rd_n=%b busy=%b done=%b",
                   e.tag, data_out, data_oe, fetch_n, rd_n, busy, done,
                   ed, eo, es, es, eb, e.d);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got no end, expected end of run");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(2, 1);                 // R1 reset state
    txn(0, 0, 0, 0, 0);         // R2 plain ten cycles
    idle(2, 0);                 // R10 done, then R9 wait ignored in idle
    txn(1, 0, 0, 0, 0);         // R6 single hold
    idle(1, 1);
    txn(0, 2, 0, 0, 0);         // R7 widened gap
    idle(1, 1);
    txn(0, 0, 3, 0, 0);         // R8 long second fetch
    idle(1, 1);
    txn(2, 1, 1, 1, 0);         // R3 start pokes during a stretched run
    txn(0, 0, 0, 0, 0);         // R10 back to back
    txn(1, 0, 0, 1, 0);
    idle(2, 1);
    txn(4, 0, 0, 0, 3);         // R1 reset while cycle 3 is stretched
    idle(2, 1);
    @(posedge clk);
    #8;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule